// File: doc/BRIEF.md
# System configuration register bank with interrupt-line source selection

This block holds a small bank of 32-bit configuration registers reached over a plain single-cycle read/write bus. Each register carries its own reset value and a per-bit write policy. A bit may be freely writable, sticky-set (a 1 stays until reset), sticky-clear (a 0 stays until reset), cleared by writing 1, or reserved (holds its reset value, writes ignored). Reads return the current register contents combinationally for the addressed word.

Four of the registers act as source selectors for sixteen external-interrupt lines. Each line picks one GPIO port through a 4-bit field. The line then follows the level of the pin with the same number on that port, and pins on every other port are blocked. The lines go on to a separate interrupt controller. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `syscfg_bank`

## Requirements
- R1: After reset, the word at offset 0x04 reads 0x7C000001, and the words at offsets 0x00, 0x08 to 0x28 all read 0x00000000.
- R2: At offset 0x00 only bits 8 and 2:0 (mask 0x00000107) can be written and read back; every other bit reads 0.
- R3: At offset 0x04, bits 31:26, 23:16 and 8 (mask 0xFCFF0100) are read/write; bits 25:24, 15:9 and 7:1 keep their reset value of 0 whatever is written.
- R4: Offset 0x04 bit 0 is sticky-clear: writing 0 clears it, and a later write of 1 leaves it at 0 until reset.
- R5: The selector words at 0x08, 0x0C, 0x10, 0x14 keep only bits 15:0 (upper half reads 0), and the key word at 0x24 keeps only bits 7:0.
- R6: At offset 0x1C, bits 3:0 are sticky-set (once 1 they stay 1 until reset), and bit 8 is cleared by writing 1 and is never set by a write.
- R7: All 32 bits of the lock words at 0x20 and 0x28 are sticky-set and are cleared only by reset.
- R8: Interrupt line n (0 to 15) uses the 4-bit field at selector word n/4 (offset 0x08 + 4*(n/4)), bits [4*(n%4)+3 : 4*(n%4)]. A field value p below the port count makes line n follow GPIO input p*16+n; after reset every field is 0, so port 0 drives all lines.
- R9: GPIO pins on ports other than the selected one have no effect on a line; a field value at or above the port count holds the line at 0.
- R10: Reads of offset 0x18 and of any offset from 0x2C up return 0, and writes there change no register.
- R11: A write takes effect at the clock edge that samples it, and a read presents the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (0 when not mapped) |
| gpio_in | input | NUM_PORTS*16 (128) | GPIO pin levels, index port*16 + pin |
| irq_line | output | 16 | Routed interrupt-line levels |

## Verification
The bench builds the block with its defaults: eight ports and 4-bit selector fields. That lets it route the highest port to the highest line, through input 127, and also drive field values of eight and above, which reach no port and must hold the line low. An 8-bit address reaches offsets past the last register, so the unmapped read and write path gets exercised alongside the sticky and write-1-to-clear bit policies.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

  localparam int NUM_REGS  = 11;
  localparam int DATA_W    = 32;
  localparam int LINES     = 16;
  localparam int SEL_W     = 4;

  localparam int IX_MAP    = 0;
  localparam int IX_CTLA   = 1;
  localparam int IX_SEL0   = 2;
  localparam int IX_STAT   = 6;
  localparam int IX_CTLB   = 7;
  localparam int IX_LOCK0  = 8;
  localparam int IX_KEY    = 9;
  localparam int IX_LOCK1  = 10;

  function automatic logic [DATA_W-1:0] rst_val(int i);
    return (i == IX_CTLA) ? 32'h7C00_0001 : 32'h0;
  endfunction

  function automatic logic [DATA_W-1:0] rw_bits(int i);
    logic [DATA_W-1:0] m;
    case (i)
      IX_MAP:  m = 32'h0000_0107;
      IX_CTLA: m = 32'hFCFF_0100;
      2, 3, 4, 5: m = 32'h0000_FFFF;
      IX_KEY:  m = 32'h0000_00FF;
      default: m = 32'h0;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] so_bits(int i);
    logic [DATA_W-1:0] m;
    case (i)
      IX_CTLB:  m = 32'h0000_000F;
      IX_LOCK0: m = 32'hFFFF_FFFF;
      IX_LOCK1: m = 32'hFFFF_FFFF;
      default:  m = 32'h0;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] co_bits(int i);
    return (i == IX_CTLA) ? 32'h0000_0001 : 32'h0;
  endfunction

  function automatic logic [DATA_W-1:0] w1c_bits(int i);
    return (i == IX_CTLB) ? 32'h0000_0100 : 32'h0;
  endfunction

endpackage

// File: rtl/syscfg_reg.sv
module syscfg_reg #(
  parameter int              W     = 32,
  parameter logic [W-1:0]    RST   = '0,
  parameter logic [W-1:0]    RW    = '0,
  parameter logic [W-1:0]    SO    = '0,
  parameter logic [W-1:0]    CO    = '0,
  parameter logic [W-1:0]    W1C   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RSV = ~(RW | SO | CO | W1C);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = (q & RSV)
          | (wdata & RW)
          | ((q | wdata) & SO)
          | ((q & wdata) & CO)
          | ((q & ~wdata) & W1C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= q_nxt;
  end

  // R6 R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(q) & SO & ~q) == '0));

  // R4
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(q) & CO & q) == '0));

  // R3
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & RSV) == (RST & RSV)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/syscfg_route.sv
module syscfg_route #(
  parameter int NUM_PORTS = 8,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input  logic [LINES*SEL_W-1:0]     sel_flat,
  input  logic [NUM_PORTS*LINES-1:0] gpio,
  output logic [LINES-1:0]           line
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] field;
    assign field = sel_flat[n*SEL_W +: SEL_W];

    always_comb begin
      line[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (field == p[SEL_W-1:0]) line[n] = gpio[p*LINES + n];
      end
    end
  end
endmodule

// File: rtl/syscfg_bank.sv
module syscfg_bank #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PORTS*16-1:0]     gpio_in,
  output logic [15:0]                 irq_line
);
  import syscfg_pkg::*;

  localparam int IDX_W   = ADDR_W - 2;
  localparam int SEL_REGS = LINES / 4;
  localparam logic [SEL_W:0] PORT_LIM = NUM_PORTS[SEL_W:0];
  localparam logic [ADDR_W-1:0] END_OFF = ADDR_W'(NUM_REGS * 4);

  logic              rst_q1, rst_sync_n;
  logic [IDX_W-1:0]  widx;
  logic              aligned;
  logic [NUM_REGS-1:0] we;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [LINES*SEL_W-1:0] sel_flat;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign we[i] = bus_sel && bus_wr && aligned && (widx == IDX_W'(i));

    syscfg_reg #(
      .W   (DATA_W),
      .RST (rst_val(i)),
      .RW  (rw_bits(i)),
      .SO  (so_bits(i)),
      .CO  (co_bits(i)),
      .W1C (w1c_bits(i))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (we[i]),
      .wdata (bus_wdata),
      .q     (regs_q[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (aligned && widx == IDX_W'(i)) bus_rdata = regs_q[i];
    end
  end

  for (genvar s = 0; s < SEL_REGS; s++) begin : g_sel
    assign sel_flat[s*16 +: 16] = regs_q[IX_SEL0 + s][15:0];
  end

  syscfg_route #(
    .NUM_PORTS (NUM_PORTS),
    .LINES     (LINES),
    .SEL_W     (SEL_W)
  ) u_route (
    .sel_flat (sel_flat),
    .gpio     (gpio_in),
    .line     (irq_line)
  );

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr >= END_OFF) |-> (bus_rdata == '0));

  // R10
  stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(IX_STAT * 4)) |-> (bus_rdata == '0));

  for (genvar n = 0; n < LINES; n++) begin : g_line_chk
    // R8
    default_port_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sel_flat[n*SEL_W +: SEL_W] == '0) |-> (irq_line[n] == gpio_in[n]));

    // R9
    no_port_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ({1'b0, sel_flat[n*SEL_W +: SEL_W]} >= PORT_LIM) |-> !irq_line[n]);
  end

endmodule

// File: tb/syscfg_bank_tb.sv
module syscfg_bank_tb;
  localparam int ADDR_W = 8;
  localparam int NP     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NP*16-1:0]  gpio_in;
  logic [15:0]       irq_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  syscfg_bank #(.ADDR_W(ADDR_W), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .irq_line(irq_line)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    gpio_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset_vals();
    rd_chk("R1 ctl_a reset", 8'h04, 32'h7C00_0001);
    for (int a = 0; a <= 'h28; a += 4)
      if (a != 4) rd_chk("R1 zero reset", a[7:0], 32'h0);
  endtask

  task automatic t_masks();
    wr(8'h00, 32'hFFFF_FEF8); rd_chk("R2 map reserved", 8'h00, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2 map all ones", 8'h00, 32'h0000_0107);
    wr(8'h00, 32'h0);         rd_chk("R2 map cleared", 8'h00, 32'h0);
    wr(8'h04, 32'h7F00_FEFF); rd_chk("R3 ctl_a reserved", 8'h04, 32'h7C00_0001);
    wr(8'h04, 32'hFFFF_FFFF); rd_chk("R3 ctl_a rw set", 8'h04, 32'hFCFF_0101);
    wr(8'h04, 32'h0000_0001); rd_chk("R3 ctl_a rw clear", 8'h04, 32'h0000_0001);
    for (int a = 8; a <= 'h14; a += 4) begin
      wr(a[7:0], 32'hFFFF_FFFF); rd_chk("R5 sel low half", a[7:0], 32'h0000_FFFF);
      wr(a[7:0], 32'h0);         rd_chk("R5 sel cleared", a[7:0], 32'h0);
    end
    wr(8'h24, 32'hFFFF_FF5A); rd_chk("R5 key byte", 8'h24, 32'h0000_005A);
    wr(8'h24, 32'h0);         rd_chk("R5 key cleared", 8'h24, 32'h0);
  endtask

  task automatic t_sticky_clear();
    wr(8'h04, 32'h0); rd_chk("R4 bit0 cleared", 8'h04, 32'h0);
    wr(8'h04, 32'h0000_0001); rd_chk("R4 bit0 stays 0", 8'h04, 32'h0);
    do_reset();
    rd_chk("R4 bit0 back after reset", 8'h04, 32'h7C00_0001);
  endtask

  task automatic t_ctl_b();
    wr(8'h1C, 32'h0000_0100); rd_chk("R6 w1c not set", 8'h1C, 32'h0);
    wr(8'h1C, 32'h0000_0005); wr(8'h1C, 32'h0000_000A);
    rd_chk("R6 sticky accumulates", 8'h1C, 32'h0000_000F);
    wr(8'h1C, 32'h0); rd_chk("R6 sticky holds", 8'h1C, 32'h0000_000F);
  endtask

  task automatic t_locks();
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h20, 32'h0);
    rd_chk("R7 lock0 holds", 8'h20, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0000_0030); wr(8'h28, 32'h8000_0000);
    rd_chk("R7 lock1 accumulates", 8'h28, 32'h8000_0030);
    do_reset();
    rd_chk("R7 lock0 reset", 8'h20, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(8'h24, 32'h0000_0033);
    wr(8'h2C, 32'hFFFF_FFFF); rd_chk("R10 0x2C reads 0", 8'h2C, 32'h0);
    wr(8'hFC, 32'hFFFF_FFFF); rd_chk("R10 0xFC reads 0", 8'hFC, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); rd_chk("R10 stat reads 0", 8'h18, 32'h0);
    rd_chk("R10 key untouched", 8'h24, 32'h0000_0033);
    rd_chk("R10 ctl_a untouched", 8'h04, 32'h7C00_0001);
    // same-cycle read visibility
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h24; bus_wdata = 32'h77;
    #1 check("R11 old value before edge", bus_rdata, 32'h33);
    @(posedge clk); #1 check("R11 new value after edge", bus_rdata, 32'h77);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic t_route();
    @(negedge clk); gpio_in = '0; gpio_in[0] = 1'b1;
    #1 check("R8 port0 line0", {16'h0, irq_line}, 32'h0000_0001);
    @(negedge clk); gpio_in = '0; gpio_in[16] = 1'b1;
    #1 check("R9 port1 blocked", {16'h0, irq_line}, 32'h0);
    gpio_in = '0;
    wr(8'h08, 32'h0000_0001);
    @(negedge clk); gpio_in[0] = 1'b1;
    #1 check("R9 port0 blocked after select", {16'h0, irq_line}, 32'h0);
    @(negedge clk); gpio_in = '0; gpio_in[16] = 1'b1;
    #1 check("R8 port1 line0", {16'h0, irq_line}, 32'h0000_0001);
    gpio_in = '0;
    wr(8'h08, 32'h0000_0010);
    @(negedge clk); gpio_in[17] = 1'b1;
    #1 check("R8 port1 line1", {16'h0, irq_line}, 32'h0000_0002);
    @(negedge clk); gpio_in = '0;
    wr(8'h08, 32'h0);
    wr(8'h14, 32'h0000_7000);
    @(negedge clk); gpio_in[7*16+15] = 1'b1;
    #1 check("R8 port7 line15", {16'h0, irq_line}, 32'h0000_8000);
    @(negedge clk); gpio_in = '0; gpio_in[15] = 1'b1;
    #1 check("R9 port0 blocked line15", {16'h0, irq_line}, 32'h0);
    wr(8'h14, 32'h0000_9000);
    @(negedge clk); gpio_in = '1;
    #1 check("R9 out-of-range field", {16'h0, irq_line}, 32'h0000_7FFF);
    wr(8'h14, 32'h0000_F000);
    #1 check("R9 field 15", {16'h0, irq_line}, 32'h0000_7FFF);
    @(negedge clk); gpio_in = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    t_reset_vals();
    t_masks();
    t_sticky_clear();
    t_ctl_b();
    t_locks();
    do_reset();
    t_unmapped();
    do_reset();
    t_route();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule